// File: doc/BRIEF.md
# Peripheral Register Window Decoder

This block sits between a simple read/write request port and a set of peripheral register banks inside a control-register address space. Each request carries a 32-bit address. The decoder first folds away the three top address bits, so every mirrored alias of a register reaches the same slot. It then picks a bank from the middle address bits and a word slot from the low byte. Each bank has its own upper address limit for reads and its own limit for writes, and the two limits may differ. Accesses beyond a limit read as zero or are dropped.

Every slot has a fixed access attribute, set by parameter:

- **No access**: the slot does not exist.
- **Read-only**: stored value that only reset sets.
- **Plain storage**: local storage.
- **Storage with hooks**: reads or writes are routed to an external hook port instead of the local word.

Two further bank addresses stand for write-only DRAM-mode settings. Writes to them are accepted silently, and reads of them return zero. An access whose bank matches nothing returns zero and sets a sticky status flag.

Read data is registered. It appears one clock after the read strobe, together with a valid pulse. Per-slot select and write-enable vectors show which slot each access reached.

Top module: `regWindowDecoder`

## Requirements
- R1: Addresses that differ only in bits [31:29] reach the same slot. The hook port address is the address with those bits cleared.
- R2: The bank is the first bank whose 13-bit hash equals address bits [28:16]; bank b's hash sits at `BANK_HASH[13b+12:13b]`. The slot is address bits [7:2], and its flat index is i = bank*SLOTS+slot. Slot i's 4-bit attribute is `SLOT_ATTR[4i+3:4i]`: bits [1:0] hold the kind (0 none, 1 read-only, 2 storage), bit 2 is the read hook and bit 3 is the write hook. `slotSel[i]` is high, combinationally, during an in-limit read or write of a slot of kind 1 or 2, and `slotSel` is zero otherwise.
- R3: A read of a masked address above the bank's read limit returns zero. A write above the bank's write limit changes nothing and raises no select, enable or hook. A bank whose read limit exceeds its write limit by 8 therefore has two top words that can be read but not written.
- R4: A slot of kind none reads zero and ignores writes.
- R5: A read-only slot ignores writes and reads its reset value, zero.
- R6: A write to an in-limit storage slot without the write hook raises `slotWe[i]` only, during the strobe cycle. Later reads return the written word.
- R7: A read of an in-limit storage slot with the read hook raises `hookRdEn` during the strobe cycle. The read returns the `hookRdData` present in that cycle.
- R8: A write to an in-limit storage slot with the write hook raises `hookWrEn`, with `hookAddr` and `hookWrData` carrying the masked address and the data. No `slotWe` bit rises, and the local word is left unchanged.
- R9: Accesses to either of the two write-only bank hashes in `WO_HASH` read zero. They raise no select, enable or hook, and they do not set the unmapped flag.
- R10: An access whose hash matches no bank and no write-only hash reads zero. It sets `unmappedFlag` from the next clock onward, and the flag stays set until reset.
- R11: `rdValid` is high exactly in the cycle after a read strobe. `rdData` changes only on such a cycle and holds its value otherwise.
- R12: Reset clears every storage slot, `rdValid`, `rdData` and `unmappedFlag`. With default parameters every slot is of kind none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 32 | Request address |
| wrData | input | 32 | Write data |
| wrStb | input | 1 | Write strobe, one cycle per write |
| rdStb | input | 1 | Read strobe, one cycle per read |
| hookRdData | input | 32 | Data returned by the read hook in the strobe cycle |
| rdData | output | 32 | Registered read data |
| rdValid | output | 1 | High in the cycle after a read strobe |
| slotSel | output | NUM_BANKS*SLOTS | One-hot select of the slot being accessed |
| slotWe | output | NUM_BANKS*SLOTS | One-hot write enable into local storage |
| hookRdEn | output | 1 | Read routed to the hook port |
| hookWrEn | output | 1 | Write routed to the hook port |
| hookAddr | output | 32 | Masked address toward the hook port |
| hookWrData | output | 32 | Write data toward the hook port |
| unmappedFlag | output | 1 | Sticky flag for an access to an unmapped bank |

## Verification
The bench builds the decoder with three banks of eight slots, 24 slots in all, which makes a full sweep of every slot practical. One bank has a read limit two words above its write limit, and read-hook slots sit in that gap, so a read there returns a non-zero value that proves the word is readable while writes to it are dropped. A second bank carries every attribute kind, including both hook directions. The third bank ends its limit on a read-only slot. Writes and reads use different address aliases, so each slot's routing, the limits and the alias folding are all checked against an arithmetic model.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  localparam int HASH_W    = 13;   // address bits [28:16]
  localparam int LIM_W     = 29;   // masked address width
  localparam int ATTR_W    = 4;
  localparam int IDX_W     = 8;    // flat slot index, up to 256 slots
  localparam int MAX_BANKS = 16;
  localparam logic [31:0] ALIAS_MASK = 32'h1FFF_FFFF;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_RO   = 2'd1,
    KIND_RW   = 2'd2
  } slotKind_e;

  typedef struct packed {
    logic      wrHook;
    logic      rdHook;
    slotKind_e kind;
  } slotAttr_t;

  // Strobes from the decode control to the datapath
  typedef struct packed {
    logic             anyRd;
    logic             localRd;
    logic             hookRd;
    logic             localWr;
    logic             hookWr;
    logic             selHit;
    logic             unmapped;
    logic [IDX_W-1:0] idx;
  } winStrobe_t;

  // Default bank hashes: evenly spread, one every 8 hash steps
  function automatic logic [MAX_BANKS*HASH_W-1:0] spreadHashes();
    logic [MAX_BANKS*HASH_W-1:0] v;
    v = '0;
    for (int b = 0; b < MAX_BANKS; b++) begin
      v[b*HASH_W +: HASH_W] = 13'h1F00 + 13'(b * 8);
    end
    return v;
  endfunction

endpackage

// File: rtl/winDecodeCtrl.sv
module winDecodeCtrl
  import regwin_pkg::*;
#(
  parameter int NUM_BANKS = 10,
  parameter int SLOTS     = 16,
  parameter logic [NUM_BANKS*HASH_W-1:0]      BANK_HASH = '0,
  parameter logic [NUM_BANKS*LIM_W-1:0]       RD_LIMIT  = '0,
  parameter logic [NUM_BANKS*LIM_W-1:0]       WR_LIMIT  = '0,
  parameter logic [NUM_BANKS*SLOTS*ATTR_W-1:0] SLOT_ATTR = '0,
  parameter logic [2*HASH_W-1:0]              WO_HASH   = '0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] addr,
  input  logic        rdStb,
  input  logic        wrStb,
  output logic [31:0] maskedAddr,
  output winStrobe_t  strb
);

  localparam int NSLOT = NUM_BANKS * SLOTS;

  logic [LIM_W-1:0]     mAddr;
  logic [HASH_W-1:0]    hash;
  logic [5:0]           wordIdx;
  logic [NUM_BANKS-1:0] bankHit, rdOk, wrOk;
  logic [1:0]           woHit;

  assign maskedAddr = addr & ALIAS_MASK;
  assign mAddr      = maskedAddr[LIM_W-1:0];
  assign hash       = mAddr[28:16];
  assign wordIdx    = mAddr[7:2];

  // Per-bank hash match and limit comparators, all in parallel
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bankHit[b] = (hash == BANK_HASH[b*HASH_W +: HASH_W]);
    assign rdOk[b]    = (mAddr <= RD_LIMIT[b*LIM_W +: LIM_W]);
    assign wrOk[b]    = (mAddr <= WR_LIMIT[b*LIM_W +: LIM_W]);
  end

  for (genvar w = 0; w < 2; w++) begin : g_wo
    assign woHit[w] = (hash == WO_HASH[w*HASH_W +: HASH_W]);
  end

  logic      found, rdIn, wrIn, slotOk, rdGo, wrGo, liveKind;
  int        bankIdx, flat;
  slotAttr_t attr;

  always_comb begin
    found   = 1'b0;
    bankIdx = 0;
    rdIn    = 1'b0;
    wrIn    = 1'b0;
    // First matching bank wins
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (!found && bankHit[b]) begin
        found   = 1'b1;
        bankIdx = b;
        rdIn    = rdOk[b];
        wrIn    = wrOk[b];
      end
    end
    slotOk   = found && (int'(wordIdx) < SLOTS);
    flat     = slotOk ? (bankIdx * SLOTS + int'(wordIdx)) : 0;
    attr     = slotOk ? slotAttr_t'(SLOT_ATTR[flat*ATTR_W +: ATTR_W]) : '0;
    liveKind = (attr.kind == KIND_RO) || (attr.kind == KIND_RW);
    rdGo     = rdStb && slotOk && rdIn && liveKind;
    wrGo     = wrStb && slotOk && wrIn && liveKind;

    strb          = '0;
    strb.anyRd    = rdStb;
    strb.idx      = IDX_W'(flat);
    strb.selHit   = rdGo || wrGo;
    strb.hookRd   = rdGo && (attr.kind == KIND_RW) && attr.rdHook;
    strb.localRd  = rdGo && !((attr.kind == KIND_RW) && attr.rdHook);
    strb.hookWr   = wrGo && (attr.kind == KIND_RW) && attr.wrHook;
    strb.localWr  = wrGo && (attr.kind == KIND_RW) && !attr.wrHook;
    strb.unmapped = (rdStb || wrStb) && !found && !(|woHit);
  end

  // R9
  wo_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|woHit) && !found) |-> !(strb.localWr || strb.hookWr || strb.selHit ||
                               strb.unmapped || strb.hookRd || strb.localRd));

  // R2
  sel_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.selHit |-> (int'(strb.idx) < NSLOT));

endmodule

// File: rtl/winDatapath.sv
module winDatapath
  import regwin_pkg::*;
#(
  parameter int NUM_BANKS = 10,
  parameter int SLOTS     = 16,
  parameter logic [NUM_BANKS*SLOTS*ATTR_W-1:0] SLOT_ATTR = '0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  winStrobe_t                 strb,
  input  logic [31:0]                maskedAddr,
  input  logic [31:0]                wrData,
  input  logic [31:0]                hookRdData,
  output logic [31:0]                rdData,
  output logic                       rdValid,
  output logic [NUM_BANKS*SLOTS-1:0] slotSel,
  output logic [NUM_BANKS*SLOTS-1:0] slotWe,
  output logic                       hookRdEn,
  output logic                       hookWrEn,
  output logic [31:0]                hookAddr,
  output logic [31:0]                hookWrData,
  output logic                       unmappedFlag
);

  localparam int NSLOT = NUM_BANKS * SLOTS;

  logic [NSLOT*32-1:0] storeFlat;

  assign slotWe  = strb.localWr ? (NSLOT'(1) << strb.idx) : '0;
  assign slotSel = strb.selHit  ? (NSLOT'(1) << strb.idx) : '0;

  // Only storage slots get flops; none/read-only slots are constant zero
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam logic [1:0] KIND = SLOT_ATTR[i*ATTR_W +: 2];
    if (KIND == KIND_RW) begin : g_rw
      logic [31:0] word;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          word <= '0;
        else if (slotWe[i]) word <= wrData;
      end
      assign storeFlat[i*32 +: 32] = word;
    end else begin : g_const
      assign storeFlat[i*32 +: 32] = '0;
    end
  end

  assign hookRdEn   = strb.hookRd;
  assign hookWrEn   = strb.hookWr;
  assign hookAddr   = maskedAddr;
  assign hookWrData = wrData;

  int          rdIdx;
  logic [31:0] nextRd;

  always_comb begin
    rdIdx = (int'(strb.idx) < NSLOT) ? int'(strb.idx) : 0;
    if (strb.hookRd)       nextRd = hookRdData;
    else if (strb.localRd) nextRd = storeFlat[rdIdx*32 +: 32];
    else                   nextRd = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData       <= '0;
      rdValid      <= 1'b0;
      unmappedFlag <= 1'b0;
    end else begin
      rdValid <= strb.anyRd;
      if (strb.anyRd)    rdData       <= nextRd;
      if (strb.unmapped) unmappedFlag <= 1'b1;
    end
  end

  // R11
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.anyRd |=> rdValid);

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.anyRd |=> (!rdValid && $stable(rdData)));

  // R10
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.unmapped |=> unmappedFlag);

  // R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    unmappedFlag |=> unmappedFlag);

  // R6
  we_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(slotWe));

  // R8
  hook_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    hookWrEn |-> (slotWe == '0));

endmodule

// File: rtl/regWindowDecoder.sv
module regWindowDecoder
  import regwin_pkg::*;
#(
  parameter int NUM_BANKS = 10,
  parameter int SLOTS     = 16,
  parameter logic [NUM_BANKS*HASH_W-1:0]       BANK_HASH = (NUM_BANKS*HASH_W)'(regwin_pkg::spreadHashes()),
  parameter logic [NUM_BANKS*LIM_W-1:0]        RD_LIMIT  = {NUM_BANKS{29'h1FFF_FFFF}},
  parameter logic [NUM_BANKS*LIM_W-1:0]        WR_LIMIT  = {NUM_BANKS{29'h1FFF_FFFF}},
  parameter logic [NUM_BANKS*SLOTS*ATTR_W-1:0] SLOT_ATTR = '0,
  parameter logic [2*HASH_W-1:0]               WO_HASH   = {13'h1F94, 13'h1F90}
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [31:0]                addr,
  input  logic [31:0]                wrData,
  input  logic                       wrStb,
  input  logic                       rdStb,
  input  logic [31:0]                hookRdData,
  output logic [31:0]                rdData,
  output logic                       rdValid,
  output logic [NUM_BANKS*SLOTS-1:0] slotSel,
  output logic [NUM_BANKS*SLOTS-1:0] slotWe,
  output logic                       hookRdEn,
  output logic                       hookWrEn,
  output logic [31:0]                hookAddr,
  output logic [31:0]                hookWrData,
  output logic                       unmappedFlag
);

  winStrobe_t  strb;
  logic [31:0] maskedAddr;

  winDecodeCtrl #(
    .NUM_BANKS(NUM_BANKS), .SLOTS(SLOTS), .BANK_HASH(BANK_HASH),
    .RD_LIMIT(RD_LIMIT), .WR_LIMIT(WR_LIMIT), .SLOT_ATTR(SLOT_ATTR),
    .WO_HASH(WO_HASH)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .addr(addr), .rdStb(rdStb), .wrStb(wrStb),
    .maskedAddr(maskedAddr), .strb(strb)
  );

  winDatapath #(
    .NUM_BANKS(NUM_BANKS), .SLOTS(SLOTS), .SLOT_ATTR(SLOT_ATTR)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .maskedAddr(maskedAddr),
    .wrData(wrData), .hookRdData(hookRdData), .rdData(rdData),
    .rdValid(rdValid), .slotSel(slotSel), .slotWe(slotWe),
    .hookRdEn(hookRdEn), .hookWrEn(hookWrEn), .hookAddr(hookAddr),
    .hookWrData(hookWrData), .unmappedFlag(unmappedFlag)
  );

endmodule

// File: tb/regWindowDecoder_test.sv
module regWindowDecoder_test;

  localparam int NB = 3;
  localparam int NS = 8;
  localparam int NT = NB * NS;
  localparam logic [NB*13-1:0] HASH_P = {13'h1FD0, 13'h1F20, 13'h1F00};
  localparam logic [NB*29-1:0] RDL_P  = {29'h1FD0_0010, 29'h1F20_001C, 29'h1F00_0014};
  localparam logic [NB*29-1:0] WRL_P  = {29'h1FD0_0010, 29'h1F20_001C, 29'h1F00_000C};
  localparam logic [NT*4-1:0]  ATTR_P = {32'h0001_2222, 32'h02EA_6210, 32'h6666_2222};
  localparam logic [31:0]      HKEY   = 32'h5A5A_0000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [31:0]   addr = '0, wrData = '0, hookRdData;
  logic          wrStb = 1'b0, rdStb = 1'b0;
  logic [31:0]   rdData, hookAddr, hookWrData;
  logic          rdValid, hookRdEn, hookWrEn, unmappedFlag;
  logic [NT-1:0] slotSel, slotWe;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  logic [31:0] mem [NB][NS];

  always #2 clk = ~clk;   // 250 MHz

  assign hookRdData = hookAddr ^ HKEY;

  regWindowDecoder #(
    .NUM_BANKS(NB), .SLOTS(NS), .BANK_HASH(HASH_P), .RD_LIMIT(RDL_P),
    .WR_LIMIT(WRL_P), .SLOT_ATTR(ATTR_P), .WO_HASH({13'h1F94, 13'h1F90})
  ) uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrStb(wrStb),
    .rdStb(rdStb), .hookRdData(hookRdData), .rdData(rdData), .rdValid(rdValid),
    .slotSel(slotSel), .slotWe(slotWe), .hookRdEn(hookRdEn), .hookWrEn(hookWrEn),
    .hookAddr(hookAddr), .hookWrData(hookWrData), .unmappedFlag(unmappedFlag)
  );

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] slotAddr(input int b, input int s);
    return (32'(HASH_P[b*13 +: 13]) << 16) | 32'(s * 4);
  endfunction

  task automatic doWrite(input int b, input int s, input int al, input logic [31:0] d);
    logic [31:0] m;
    logic [3:0]  nib;
    logic        inR, live, expHk;
    logic [NT-1:0] oh, expSel, expWe;
    string tag;
    m     = slotAddr(b, s);
    nib   = ATTR_P[(b*NS+s)*4 +: 4];
    inR   = m <= 32'(WRL_P[b*29 +: 29]);
    live  = inR && (nib[1:0] == 2'd1 || nib[1:0] == 2'd2);
    oh    = NT'(1) << (b*NS+s);
    expSel = live ? oh : '0;
    expHk  = live && nib[1:0] == 2'd2 && nib[3];
    expWe  = (live && nib[1:0] == 2'd2 && !nib[3]) ? oh : '0;
    tag = !inR ? "R3" : (nib[1:0] == 2'd0) ? "R4" : (nib[1:0] == 2'd1) ? "R5" :
          nib[3] ? "R8" : "R6";
    @(negedge clk);
    addr = m | (32'(al) << 29); wrData = d; wrStb = 1'b1;
    #1;
    check(tag, $sformatf("slotWe b%0d s%0d", b, s), 64'(slotWe), 64'(expWe));
    check("R2", $sformatf("slotSel on write b%0d s%0d", b, s), 64'(slotSel), 64'(expSel));
    check(tag, $sformatf("hookWrEn b%0d s%0d", b, s), 64'(hookWrEn), 64'(expHk));
    if (expHk) begin
      check("R8", "hookAddr/hookWrData", {hookAddr, hookWrData}, {m, d});
    end
    if (expWe != '0) mem[b][s] = d;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic doRead(input int b, input int s, input int al, input string tagIn);
    logic [31:0] m, exp;
    logic [3:0]  nib;
    logic        inR, live, expHk;
    logic [NT-1:0] expSel;
    string tag;
    m     = slotAddr(b, s);
    nib   = ATTR_P[(b*NS+s)*4 +: 4];
    inR   = m <= 32'(RDL_P[b*29 +: 29]);
    live  = inR && (nib[1:0] == 2'd1 || nib[1:0] == 2'd2);
    expSel = live ? (NT'(1) << (b*NS+s)) : '0;
    expHk  = live && nib[1:0] == 2'd2 && nib[2];
    if (!live)       exp = '0;
    else if (expHk)  exp = m ^ HKEY;
    else if (nib[1:0] == 2'd2) exp = mem[b][s];
    else             exp = '0;
    tag = (tagIn != "") ? tagIn : !inR ? "R3" : (nib[1:0] == 2'd0) ? "R4" :
          (nib[1:0] == 2'd1) ? "R5" : nib[2] ? "R7" : "R6";
    @(negedge clk);
    addr = m | (32'(al) << 29); rdStb = 1'b1;
    #1;
    check("R2", $sformatf("slotSel on read b%0d s%0d", b, s), 64'(slotSel), 64'(expSel));
    check(tag, $sformatf("hookRdEn b%0d s%0d", b, s), 64'(hookRdEn), 64'(expHk));
    @(negedge clk);
    rdStb = 1'b0;
    check("R11", "rdValid after strobe", 64'(rdValid), 64'd1);
    check(tag, $sformatf("rdData b%0d s%0d alias %0d", b, s, al), 64'(rdData), 64'(exp));
  endtask

  task automatic rawAccess(input logic [31:0] a, input bit wr, input logic [31:0] d,
                           input string tag, input logic [31:0] expRd);
    @(negedge clk);
    addr = a; wrData = d; wrStb = wr; rdStb = !wr;
    #1;
    check(tag, "slotSel/slotWe/hooks quiet", {slotSel, slotWe, hookRdEn, hookWrEn}, '0);
    @(negedge clk);
    wrStb = 1'b0; rdStb = 1'b0;
    if (!wr) check(tag, "raw read data", 64'(rdData), 64'(expRd));
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) for (int s = 0; s < NS; s++) mem[b][s] = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", "rdValid in reset", 64'(rdValid), 64'd0);
    check("R12", "unmappedFlag in reset", 64'(unmappedFlag), 64'd0);
    check("R12", "rdData in reset", 64'(rdData), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R12", "slotWe idle", 64'(slotWe), 64'd0);
    for (int b = 0; b < NB; b++) for (int s = 0; s < NS; s++) doRead(b, s, 0, "");
    // R11 idle cycle after a read: valid drops, data holds
    @(negedge clk);
    check("R11", "rdValid idle", 64'(rdValid), 64'd0);
    check("R11", "rdData held", 64'(rdData), 64'd0);

    // Write sweep and read sweep through different aliases (R1)
    for (int b = 0; b < NB; b++)
      for (int s = 0; s < NS; s++)
        doWrite(b, s, (b + s) % 8, {8'(b + 1), 8'(s + 1), 16'hC0DE ^ 16'(b*37 + s*11)});
    for (int b = 0; b < NB; b++)
      for (int s = 0; s < NS; s++)
        doRead(b, s, (b + s + 3) % 8, "");
    doWrite(1, 6, 0, 32'hA11A_5E00);
    doRead(1, 6, 7, "R1");
    doRead(0, 2, 5, "R1");

    // R9 write-only banks
    rawAccess(32'hFF90_0004, 1'b1, 32'h1234_5678, "R9", '0);
    rawAccess(32'h1F94_0008, 1'b1, 32'h8765_4321, "R9", '0);
    rawAccess(32'hFF90_0004, 1'b0, '0, "R9", '0);
    rawAccess(32'h1F94_0008, 1'b0, '0, "R9", '0);
    check("R9", "unmappedFlag after write-only access", 64'(unmappedFlag), 64'd0);

    // R10 unmapped bank
    rawAccess(32'hFF40_0010, 1'b0, '0, "R10", '0);
    check("R10", "unmappedFlag set", 64'(unmappedFlag), 64'd1);
    doRead(0, 1, 2, "");
    check("R10", "unmappedFlag sticky", 64'(unmappedFlag), 64'd1);

    // R12 reset clears storage and flag
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    for (int b = 0; b < NB; b++) for (int s = 0; s < NS; s++) mem[b][s] = '0;
    check("R12", "unmappedFlag after reset", 64'(unmappedFlag), 64'd0);
    doRead(0, 0, 4, "R12");
    doRead(1, 6, 1, "R12");
    doRead(2, 3, 6, "R12");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule